// File: doc/BRIEF.md
# AC-link Modem Slot Framer

This block moves the modem streams of a serial AC-link frame between a bit-serial codec link and parallel words. It produces the frame timing itself: every 256 bit clocks it raises `sync` for the 16-bit tag slot and shifts one frame out on `sdata_out`, MSB first. The outbound frame carries a tag word and the modem payload. Line 1 goes in slot 5, line 2 in slot 10 and the handset in slot 11, each as a 20-bit slot word. Slot 12 carries 16 GPIO control bits directly. The register command slots and the audio PCM slots are sent as zero.

On the inbound side the block samples `sdata_in` on the falling clock edge. It collects the tag, the three ADC samples and the 16 GPIO status bits from the same slot positions. When the frame's last bit has been taken, it presents all of them at once with a one-cycle `rx_strobe`. Transmit words are taken once per frame, at the edge that ends the last bit while `frame_req` is high. The same edge captures the sample width mode, which governs both directions of the frame that follows.

The slot sequencer is a state machine with eight states. SL_TAG (slot 0, 16 bits) moves to SL_CMD (slots 1–2, 40 bits). SL_CMD moves to SL_PCMA (slots 3–4, 40 bits), then SL_LINE1 (slot 5). Next come SL_PCMB (slots 6–9, 80 bits), SL_LINE2 (slot 10), SL_HSET (slot 11) and SL_GPIO (slot 12). SL_GPIO returns to SL_TAG. Each transition is taken on the last bit of the current state's span. Reset enters SL_TAG at bit 0.

Top module: `acl_modem_framer`

## Requirements
- R1: A frame is 256 bit clocks. Frame bit 0 is the first clock after reset is released. `sync` is high for frame bits 0..15 and low for bits 16..255 of every frame.
- R2: Frame bits 0..15 send the tag MSB first, with tag bit 15 at frame bit 0. Tag bit 15 is set when any payload slot is valid. Bit 10 flags line 1, bit 5 flags line 2, bit 4 flags the handset and bit 3 flags GPIO. All other tag bits are zero.
- R3: A slot word occupies 20 frame bits, MSB first. Slot word bit 19 goes out first. Line 1 starts at frame bit 96, line 2 at frame bit 196 and the handset at frame bit 216. An invalid stream's slot is sent as all zeros.
- R4: With `wide_mode`=0, slot word bits 3..0 are zero on output, and the same bits are forced to zero in the received samples. With `wide_mode`=1 all 20 bits pass in both directions. The mode is captured with the transmit words and applies to the next frame.
- R5: `tx_gpio[15:0]` goes to slot 12 bits 19..4, which are frame bits 236..251, MSB first. Frame bits 252..255 are zero. `rx_gpio` takes inbound slot 12 bits 19..4, and the inbound bits 3..0 of that slot are ignored.
- R6: Frame bits 16..95 and 116..195 (slots 1–4 and 6–9) are sent as zero. Inbound data in those bits has no effect on any output.
- R7: `frame_req` is high only during frame bit 255. The transmit words, valid flags and mode are captured at the rising edge that ends that bit. The first frame after reset is all zero.
- R8: `sdata_in` is sampled on the falling edge. `rx_strobe` is high for exactly the one cycle after frame bit 255. All rx outputs change only at that edge and hold between strobes.
- R9: `rx_frame_vld`, `rx_line1_vld`, `rx_line2_vld`, `rx_hset_vld` and `rx_gpio_vld` copy inbound tag bits 15, 10, 5, 4 and 3. The rx sample words are updated whatever their flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: 20-bit samples, 0: 16-bit with zeroed low bits |
| tx_line1 | input | 20 | Line 1 DAC slot word |
| tx_line1_vld | input | 1 | Line 1 word is fresh |
| tx_line2 | input | 20 | Line 2 DAC slot word |
| tx_line2_vld | input | 1 | Line 2 word is fresh |
| tx_hset | input | 20 | Handset DAC slot word |
| tx_hset_vld | input | 1 | Handset word is fresh |
| tx_gpio | input | 16 | GPIO control bits |
| tx_gpio_vld | input | 1 | GPIO word is fresh |
| frame_req | output | 1 | High during the last bit of a frame; inputs are captured at its end |
| sync | output | 1 | Frame sync, high across the tag slot |
| sdata_out | output | 1 | Serial outbound data |
| sdata_in | input | 1 | Serial inbound data |
| rx_line1 | output | 20 | Line 1 ADC slot word |
| rx_line2 | output | 20 | Line 2 ADC slot word |
| rx_hset | output | 20 | Handset ADC slot word |
| rx_gpio | output | 16 | GPIO status bits |
| rx_line1_vld | output | 1 | Inbound tag flag for line 1 |
| rx_line2_vld | output | 1 | Inbound tag flag for line 2 |
| rx_hset_vld | output | 1 | Inbound tag flag for handset |
| rx_gpio_vld | output | 1 | Inbound tag flag for GPIO |
| rx_frame_vld | output | 1 | Inbound tag frame-valid flag |
| rx_strobe | output | 1 | One-cycle pulse when rx outputs update |

## Verification
The sweep walks all 16 combinations of the four transmit valid flags under both sample width modes. It then adds all-ones and all-zeros payloads. The flag sweep separates a slot that is muted from one that is sent, and shows whether each tag bit follows its own stream. The mode sweep shows whether the low four bits are zero-filled in both directions. Odd vectors fill the ignored inbound slots, spare tag bits and GPIO pad bits with ones, so any leakage from them into the rx words shows up. The inbound flags are the complement of the outbound ones, so the two tag paths cannot be confused.

// File: rtl/acl_modem_pkg.sv
package acl_modem_pkg;

    // Slot numbers of the modem streams; tag flag bit of slot n is TAG_W-1-n
    localparam int SLOT_LINE1 = 5;
    localparam int SLOT_LINE2 = 10;
    localparam int SLOT_HSET  = 11;
    localparam int SLOT_GPIO  = 12;

    typedef enum logic [2:0] {
        SL_TAG,
        SL_CMD,
        SL_PCMA,
        SL_LINE1,
        SL_PCMB,
        SL_LINE2,
        SL_HSET,
        SL_GPIO
    } slot_e;

endpackage

// File: rtl/acl_slot_seq.sv
module acl_slot_seq
    import acl_modem_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int IDX_W  = $clog2(4*SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    output slot_e            slot,
    output logic [IDX_W-1:0] idx,
    output logic             slot_last,
    output logic             frame_last,
    output logic             sync
);

    slot_e            state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] span;
    logic             last_w;

    // Bit span of each state
    always_comb begin
        unique case (state_q)
            SL_TAG:           span = IDX_W'(TAG_W);
            SL_CMD, SL_PCMA:  span = IDX_W'(2*SLOT_W);
            SL_PCMB:          span = IDX_W'(4*SLOT_W);
            default:          span = IDX_W'(SLOT_W);
        endcase
    end

    assign last_w = (idx_q == span - 1'b1);

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q + 1'b1;
        if (last_w) begin
            idx_d = '0;
            unique case (state_q)
                SL_TAG:   state_d = SL_CMD;
                SL_CMD:   state_d = SL_PCMA;
                SL_PCMA:  state_d = SL_LINE1;
                SL_LINE1: state_d = SL_PCMB;
                SL_PCMB:  state_d = SL_LINE2;
                SL_LINE2: state_d = SL_HSET;
                SL_HSET:  state_d = SL_GPIO;
                SL_GPIO:  state_d = SL_TAG;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_TAG;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs
    always_comb begin
        slot       = state_q;
        idx        = idx_q;
        slot_last  = last_w;
        frame_last = last_w && (state_q == SL_GPIO);
        sync       = (state_q == SL_TAG);
    end

endmodule

// File: rtl/acl_tx_packer.sv
module acl_tx_packer
    import acl_modem_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int SMP_W  = 16,
    parameter int GPIO_W = 16,
    parameter int IDX_W  = $clog2(4*SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              wide_mode,
    input  logic [SLOT_W-1:0] tx_line1,
    input  logic              tx_line1_vld,
    input  logic [SLOT_W-1:0] tx_line2,
    input  logic              tx_line2_vld,
    input  logic [SLOT_W-1:0] tx_hset,
    input  logic              tx_hset_vld,
    input  logic [GPIO_W-1:0] tx_gpio,
    input  logic              tx_gpio_vld,
    input  slot_e             slot,
    input  logic [IDX_W-1:0]  idx,
    output logic              sdata_out,
    output logic              frame_wide
);

    localparam int LOW_W  = SLOT_W - SMP_W;
    localparam int SEL_W  = $clog2(SLOT_W);
    localparam int TSEL_W = $clog2(TAG_W);

    logic [TAG_W-1:0]  snap_tag, tag_d;
    logic [SLOT_W-1:0] snap_l1, snap_l2, snap_hs, snap_gp;
    logic              snap_wide;
    logic [SEL_W-1:0]  s_sel;
    logic [TSEL_W-1:0] t_sel;

    function automatic logic [SLOT_W-1:0] fit(input logic [SLOT_W-1:0] v,
                                              input logic wide, input logic vld);
        logic [SLOT_W-1:0] r;
        r = {v[SLOT_W-1:LOW_W], (wide ? v[LOW_W-1:0] : {LOW_W{1'b0}})};
        return vld ? r : '0;
    endfunction

    always_comb begin
        tag_d = '0;
        tag_d[TAG_W-1]            = tx_line1_vld | tx_line2_vld | tx_hset_vld | tx_gpio_vld;
        tag_d[TAG_W-1-SLOT_LINE1] = tx_line1_vld;
        tag_d[TAG_W-1-SLOT_LINE2] = tx_line2_vld;
        tag_d[TAG_W-1-SLOT_HSET]  = tx_hset_vld;
        tag_d[TAG_W-1-SLOT_GPIO]  = tx_gpio_vld;
    end

    // Frame snapshot, taken on the edge that ends the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_tag  <= '0;
            snap_l1   <= '0;
            snap_l2   <= '0;
            snap_hs   <= '0;
            snap_gp   <= '0;
            snap_wide <= 1'b0;
        end else if (capture) begin
            snap_tag  <= tag_d;
            snap_l1   <= fit(tx_line1, wide_mode, tx_line1_vld);
            snap_l2   <= fit(tx_line2, wide_mode, tx_line2_vld);
            snap_hs   <= fit(tx_hset, wide_mode, tx_hset_vld);
            snap_gp   <= tx_gpio_vld ? {tx_gpio, {(SLOT_W-GPIO_W){1'b0}}} : '0;
            snap_wide <= wide_mode;
        end
    end

    assign s_sel = SEL_W'(SLOT_W-1) - SEL_W'(idx);
    assign t_sel = TSEL_W'(TAG_W-1) - TSEL_W'(idx);

    // Bit multiplexer, MSB first within each slot
    always_comb begin
        unique case (slot)
            SL_TAG:   sdata_out = snap_tag[t_sel];
            SL_LINE1: sdata_out = snap_l1[s_sel];
            SL_LINE2: sdata_out = snap_l2[s_sel];
            SL_HSET:  sdata_out = snap_hs[s_sel];
            SL_GPIO:  sdata_out = snap_gp[s_sel];
            default:  sdata_out = 1'b0;
        endcase
    end

    assign frame_wide = snap_wide;

endmodule

// File: rtl/acl_rx_unpacker.sv
module acl_rx_unpacker
    import acl_modem_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int SMP_W  = 16,
    parameter int GPIO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_in,
    input  slot_e             slot,
    input  logic              slot_last,
    input  logic              frame_last,
    input  logic              frame_wide,
    output logic [SLOT_W-1:0] rx_line1,
    output logic [SLOT_W-1:0] rx_line2,
    output logic [SLOT_W-1:0] rx_hset,
    output logic [GPIO_W-1:0] rx_gpio,
    output logic              rx_line1_vld,
    output logic              rx_line2_vld,
    output logic              rx_hset_vld,
    output logic              rx_gpio_vld,
    output logic              rx_frame_vld,
    output logic              rx_strobe
);

    localparam int LOW_W = SLOT_W - SMP_W;

    logic              bit_n;
    logic [SLOT_W-1:0] sh_q, word_now;
    logic [TAG_W-1:0]  hold_tag;
    logic [SLOT_W-1:0] hold_l1, hold_l2, hold_hs;

    function automatic logic [SLOT_W-1:0] trim(input logic [SLOT_W-1:0] v, input logic wide);
        return {v[SLOT_W-1:LOW_W], (wide ? v[LOW_W-1:0] : {LOW_W{1'b0}})};
    endfunction

    // Inbound bit taken mid bit time
    always_ff @(negedge clk) begin
        if (!rst_n) bit_n <= 1'b0;
        else        bit_n <= sdata_in;
    end

    assign word_now = {sh_q[SLOT_W-2:0], bit_n};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q         <= '0;
            hold_tag     <= '0;
            hold_l1      <= '0;
            hold_l2      <= '0;
            hold_hs      <= '0;
            rx_line1     <= '0;
            rx_line2     <= '0;
            rx_hset      <= '0;
            rx_gpio      <= '0;
            rx_line1_vld <= 1'b0;
            rx_line2_vld <= 1'b0;
            rx_hset_vld  <= 1'b0;
            rx_gpio_vld  <= 1'b0;
            rx_frame_vld <= 1'b0;
            rx_strobe    <= 1'b0;
        end else begin
            sh_q      <= word_now;
            rx_strobe <= frame_last;
            if (slot_last) begin
                unique case (slot)
                    SL_TAG:   hold_tag <= word_now[TAG_W-1:0];
                    SL_LINE1: hold_l1  <= word_now;
                    SL_LINE2: hold_l2  <= word_now;
                    SL_HSET:  hold_hs  <= word_now;
                    default:  ;
                endcase
            end
            if (frame_last) begin
                rx_line1     <= trim(hold_l1, frame_wide);
                rx_line2     <= trim(hold_l2, frame_wide);
                rx_hset      <= trim(hold_hs, frame_wide);
                rx_gpio      <= word_now[SLOT_W-1 -: GPIO_W];
                rx_frame_vld <= hold_tag[TAG_W-1];
                rx_line1_vld <= hold_tag[TAG_W-1-SLOT_LINE1];
                rx_line2_vld <= hold_tag[TAG_W-1-SLOT_LINE2];
                rx_hset_vld  <= hold_tag[TAG_W-1-SLOT_HSET];
                rx_gpio_vld  <= hold_tag[TAG_W-1-SLOT_GPIO];
            end
        end
    end

endmodule

// File: rtl/acl_modem_framer.sv
module acl_modem_framer
    import acl_modem_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int SMP_W  = 16,
    parameter int GPIO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic [SLOT_W-1:0] tx_line1,
    input  logic              tx_line1_vld,
    input  logic [SLOT_W-1:0] tx_line2,
    input  logic              tx_line2_vld,
    input  logic [SLOT_W-1:0] tx_hset,
    input  logic              tx_hset_vld,
    input  logic [GPIO_W-1:0] tx_gpio,
    input  logic              tx_gpio_vld,
    output logic              frame_req,
    output logic              sync,
    output logic              sdata_out,
    input  logic              sdata_in,
    output logic [SLOT_W-1:0] rx_line1,
    output logic [SLOT_W-1:0] rx_line2,
    output logic [SLOT_W-1:0] rx_hset,
    output logic [GPIO_W-1:0] rx_gpio,
    output logic              rx_line1_vld,
    output logic              rx_line2_vld,
    output logic              rx_hset_vld,
    output logic              rx_gpio_vld,
    output logic              rx_frame_vld,
    output logic              rx_strobe
);

    localparam int IDX_W = $clog2(4*SLOT_W);

    slot_e            slot;
    logic [IDX_W-1:0] idx;
    logic             slot_last, frame_last, frame_wide;

    acl_slot_seq #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .slot(slot), .idx(idx),
        .slot_last(slot_last), .frame_last(frame_last), .sync(sync)
    );

    acl_tx_packer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .SMP_W(SMP_W),
                    .GPIO_W(GPIO_W), .IDX_W(IDX_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .capture(frame_last), .wide_mode(wide_mode),
        .tx_line1(tx_line1), .tx_line1_vld(tx_line1_vld),
        .tx_line2(tx_line2), .tx_line2_vld(tx_line2_vld),
        .tx_hset(tx_hset), .tx_hset_vld(tx_hset_vld),
        .tx_gpio(tx_gpio), .tx_gpio_vld(tx_gpio_vld),
        .slot(slot), .idx(idx), .sdata_out(sdata_out), .frame_wide(frame_wide)
    );

    acl_rx_unpacker #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .SMP_W(SMP_W),
                      .GPIO_W(GPIO_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .sdata_in(sdata_in), .slot(slot),
        .slot_last(slot_last), .frame_last(frame_last), .frame_wide(frame_wide),
        .rx_line1(rx_line1), .rx_line2(rx_line2), .rx_hset(rx_hset), .rx_gpio(rx_gpio),
        .rx_line1_vld(rx_line1_vld), .rx_line2_vld(rx_line2_vld),
        .rx_hset_vld(rx_hset_vld), .rx_gpio_vld(rx_gpio_vld),
        .rx_frame_vld(rx_frame_vld), .rx_strobe(rx_strobe)
    );

    assign frame_req = frame_last;

endmodule

// File: rtl/acl_modem_framer_chk.sv
module acl_modem_framer_chk #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int SMP_W  = 16,
    parameter int GPIO_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync,
    input logic              frame_req,
    input logic              sdata_out,
    input logic              rx_strobe,
    input logic [SLOT_W-1:0] rx_line1,
    input logic [SLOT_W-1:0] rx_line2,
    input logic [SLOT_W-1:0] rx_hset,
    input logic [GPIO_W-1:0] rx_gpio
);

    localparam int FRAME_BITS = TAG_W + 12*SLOT_W;
    localparam int LOW_W      = SLOT_W - SMP_W;
    localparam int S5_START   = TAG_W + 4*SLOT_W;
    localparam int S10_START  = TAG_W + 9*SLOT_W;

    int cpos;

    always_ff @(posedge clk) begin
        if (!rst_n)                      cpos <= 0;
        else if (cpos == FRAME_BITS - 1) cpos <= 0;
        else                             cpos <= cpos + 1;
    end

    p_sync_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sync == (cpos < TAG_W));

    p_req_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req == (cpos == FRAME_BITS - 1));

    p_tag_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpos >= TAG_W - 3 && cpos < TAG_W) |-> !sdata_out);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpos >= TAG_W && cpos < S5_START) ||
         (cpos >= S5_START + SLOT_W && cpos < S10_START)) |-> !sdata_out);

    p_gpio_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpos >= FRAME_BITS - LOW_W) |-> !sdata_out);

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    p_strobe_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> cpos == 0);

    p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |-> ($stable(rx_line1) && $stable(rx_line2) &&
                        $stable(rx_hset) && $stable(rx_gpio)));

endmodule

bind acl_modem_framer acl_modem_framer_chk #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .SMP_W(SMP_W), .GPIO_W(GPIO_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sync(sync), .frame_req(frame_req),
    .sdata_out(sdata_out), .rx_strobe(rx_strobe), .rx_line1(rx_line1),
    .rx_line2(rx_line2), .rx_hset(rx_hset), .rx_gpio(rx_gpio)
);

// File: tb/acl_modem_framer_tb.sv
`timescale 1ns/1ps
module acl_modem_framer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [19:0] tx_line1 = '0, tx_line2 = '0, tx_hset = '0;
    logic [15:0] tx_gpio = '0;
    logic        tx_line1_vld = 1'b0, tx_line2_vld = 1'b0, tx_hset_vld = 1'b0, tx_gpio_vld = 1'b0;
    logic        frame_req, sync, sdata_out;
    logic        sdata_in = 1'b0;
    logic [19:0] rx_line1, rx_line2, rx_hset;
    logic [15:0] rx_gpio;
    logic        rx_line1_vld, rx_line2_vld, rx_hset_vld, rx_gpio_vld, rx_frame_vld, rx_strobe;

    always #2.5 clk = ~clk;

    acl_modem_framer dut_i (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .tx_line1(tx_line1), .tx_line1_vld(tx_line1_vld),
        .tx_line2(tx_line2), .tx_line2_vld(tx_line2_vld),
        .tx_hset(tx_hset), .tx_hset_vld(tx_hset_vld),
        .tx_gpio(tx_gpio), .tx_gpio_vld(tx_gpio_vld),
        .frame_req(frame_req), .sync(sync), .sdata_out(sdata_out), .sdata_in(sdata_in),
        .rx_line1(rx_line1), .rx_line2(rx_line2), .rx_hset(rx_hset), .rx_gpio(rx_gpio),
        .rx_line1_vld(rx_line1_vld), .rx_line2_vld(rx_line2_vld),
        .rx_hset_vld(rx_hset_vld), .rx_gpio_vld(rx_gpio_vld),
        .rx_frame_vld(rx_frame_vld), .rx_strobe(rx_strobe)
    );

    int n_chk = 0;
    int n_bad = 0;
    int bpos  = 0;
    int sync_bad = 0;
    int req_bad  = 0;

    logic [255:0] out_cur  = '0;
    logic [255:0] last_out = '0;
    logic [255:0] cur_in   = '0;
    logic [255:0] next_in  = '0;
    logic [255:0] exp_out  = '0;
    logic [255:0] idle_mask = '0;

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] put(input logic [255:0] f, input int start,
                                         input int w, input logic [19:0] v);
        logic [255:0] r;
        r = f;
        for (int k = 0; k < w; k++) r[255-(start+k)] = v[w-1-k];
        return r;
    endfunction

    function automatic logic [19:0] get(input logic [255:0] f, input int start, input int w);
        logic [19:0] r;
        r = '0;
        for (int k = 0; k < w; k++) r[w-1-k] = f[255-(start+k)];
        return r;
    endfunction

    function automatic logic [19:0] trim(input logic [19:0] v, input logic wide);
        return wide ? v : {v[19:4], 4'h0};
    endfunction

    // Bench position counter, independent of the design
    always @(posedge clk) begin
        int nxt;
        nxt = (!rst_n) ? 0 : ((bpos == 255) ? 0 : bpos + 1);
        if (nxt == 0) cur_in <= next_in;
        sdata_in <= (nxt == 0) ? next_in[255] : cur_in[255-nxt];
        bpos <= nxt;
    end

    // Outbound capture and frame timing observation
    always @(negedge clk) begin
        if (rst_n) begin
            out_cur[255-bpos] = sdata_out;
            if (bpos == 255) last_out = out_cur;
            if (sync !== (bpos < 16)) sync_bad++;
            if (frame_req !== (bpos == 255)) req_bad++;
        end
    end

    task automatic wait_pos(input int p);
        do @(negedge clk); while (bpos != p);
    endtask

    // Expected inbound results for the frame in flight
    logic [19:0] e_l1, e_l2, e_hs;
    logic [15:0] e_gp;
    logic [4:0]  e_flags;

    task automatic apply_vector(input int i);
        logic [3:0]  v;
        logic        w, odd;
        logic [15:0] tag, rtag;
        logic [19:0] l1, l2, hs, il1, il2, ihs, igp;
        logic [15:0] gp;
        logic [255:0] f;
        if (i < 32) begin
            v  = 4'(i);
            w  = i[4];
            l1 = 20'((i + 1) * 32'h2B5C7);
            l2 = 20'((i + 3) * 32'h1D0E9);
            hs = 20'((i * 32'h3C3C5) ^ 32'hF0F0F);
            gp = 16'(i * 32'h9E37 + 1);
        end else begin
            v  = 4'hF;
            w  = i[0];
            l1 = (i < 34) ? 20'hFFFFF : 20'h0;
            l2 = l1;
            hs = l1;
            gp = (i < 34) ? 16'hFFFF : 16'h0;
        end
        odd = i[0];
        tx_line1 = l1; tx_line2 = l2; tx_hset = hs; tx_gpio = gp;
        tx_line1_vld = v[0]; tx_line2_vld = v[1]; tx_hset_vld = v[2]; tx_gpio_vld = v[3];
        wide_mode = w;
        // Expected outbound frame
        tag = '0;
        tag[15] = |v; tag[10] = v[0]; tag[5] = v[1]; tag[4] = v[2]; tag[3] = v[3];
        f = '0;
        f = put(f, 0, 16, {4'h0, tag});
        f = put(f, 96,  20, v[0] ? trim(l1, w) : 20'h0);
        f = put(f, 196, 20, v[1] ? trim(l2, w) : 20'h0);
        f = put(f, 216, 20, v[2] ? trim(hs, w) : 20'h0);
        f = put(f, 236, 20, v[3] ? {gp, 4'h0} : 20'h0);
        exp_out = f;
        // Inbound frame: flags are the complement, spare bits filled on odd vectors
        rtag = odd ? 16'hFFFF : 16'h0000;
        rtag[15] = i[0] ^ i[4];
        rtag[10] = ~v[0]; rtag[5] = ~v[1]; rtag[4] = ~v[2]; rtag[3] = ~v[3];
        il1 = 20'(i * 32'h71A2B + 7);
        il2 = 20'(i * 32'h5F3D1 + 32'hC0DE);
        ihs = (i >= 32) ? ((i < 34) ? 20'hFFFFF : 20'h0) : 20'(~(i * 32'h13579));
        igp = {16'(i * 32'hB1C3 + 5), (odd ? 4'hF : 4'h0)};
        f = odd ? ~256'h0 : 256'h0;
        f = put(f, 0, 16, {4'h0, rtag});
        f = put(f, 96,  20, il1);
        f = put(f, 196, 20, il2);
        f = put(f, 216, 20, ihs);
        f = put(f, 236, 20, igp);
        next_in = f;
        e_l1 = trim(il1, w); e_l2 = trim(il2, w); e_hs = trim(ihs, w);
        e_gp = igp[19:4];
        e_flags = {rtag[15], rtag[10], rtag[5], rtag[4], rtag[3]};
    endtask

    initial begin
        for (int p = 16; p < 96; p++)  idle_mask[255-p] = 1'b1;
        for (int p = 116; p < 196; p++) idle_mask[255-p] = 1'b1;
        repeat (3) @(negedge clk);
        // R7 reset state
        check("R7 reset sdata_out", 256'(sdata_out), 256'(0));
        check("R7 reset rx_strobe", 256'(rx_strobe), 256'(0));
        check("R7 reset rx words", {rx_line1, rx_line2, rx_hset, rx_gpio}, 256'(0));
        rst_n = 1'b1;
        wait_pos(0);
        // First frame after reset is all zero; first strobe delivers a zero frame
        check("R7 first frame zero", last_out, 256'(0));
        check("R8 first strobe", 256'(rx_strobe), 256'(1));
        for (int i = 0; i < 36; i++) begin
            wait_pos(200);
            apply_vector(i);
            wait_pos(0);
            wait_pos(0);
            check("R2 tag field", 256'(get(last_out, 0, 16)), 256'(get(exp_out, 0, 16)));
            check("R3 R4 line1 slot", 256'(get(last_out, 96, 20)), 256'(get(exp_out, 96, 20)));
            check("R3 R4 line2 slot", 256'(get(last_out, 196, 20)), 256'(get(exp_out, 196, 20)));
            check("R3 R4 hset slot", 256'(get(last_out, 216, 20)), 256'(get(exp_out, 216, 20)));
            check("R5 gpio slot", 256'(get(last_out, 236, 20)), 256'(get(exp_out, 236, 20)));
            check("R6 idle slots zero", last_out & idle_mask, 256'(0));
            check("R8 strobe after frame", 256'(rx_strobe), 256'(1));
            check("R4 R6 rx samples", {rx_line1, rx_line2, rx_hset}, {e_l1, e_l2, e_hs});
            check("R5 rx gpio", 256'(rx_gpio), 256'(e_gp));
            check("R9 rx flags",
                  256'({rx_frame_vld, rx_line1_vld, rx_line2_vld, rx_hset_vld, rx_gpio_vld}),
                  256'(e_flags));
            @(negedge clk);
            check("R8 strobe one cycle", 256'(rx_strobe), 256'(0));
            check("R8 rx held", 256'(rx_line1), 256'(e_l1));
        end
        check("R1 sync window", 256'(sync_bad), 256'(0));
        check("R7 frame_req timing", 256'(req_bad), 256'(0));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule